// File: doc/BRIEF.md
# Smart card character transceiver

This block sends and receives characters over a single shared open-drain data line. An external pull-up keeps the line high, and the block only ever pulls it low or lets it go. A character is ten bits on the line: a low start bit, the eight data bits with the least significant bit first, and an even parity bit. All timing is counted in pulses of an external enable, `tick`, which arrives `TPB` times per bit period. Since the line is shared, transmission and reception never overlap. The transmitter waits until the receiver is idle, and the receiver ignores the line while a character is being sent.

In normal mode the receiver checks parity. On a good character it hands the byte over with a one-cycle `rx_valid` pulse. On a bad character it sets `err_flag` and pulls the line low for `ERR_BITS` bit periods, starting half a bit after the parity bit ends. After each character the transmitter keeps the line released for two bit periods. One bit period after its parity bit ends, it samples the line for that low error signal. If the error signal was there, it sends the same byte again, up to `RETRIES` times. After the last retry it drops the byte and pulses `retry_fail`. In block mode (`block_mode` = 1) a parity error still sets `err_flag`, but nothing is driven on the line and the transmitter ignores the line after its character. While the flag is set in block mode, any character whose parity bit arrives is dropped.

Transmitter states:
- `TX_IDLE` goes to `TX_BITS` on an accepted byte.
- `TX_BITS` goes to `TX_GUARD` after the tenth bit.
- `TX_GUARD` goes to `TX_BITS` on a retry, or to `TX_IDLE` when the byte is done or dropped.

Receiver states:
- `RX_IDLE` goes to `RX_START` when a tick sees the line low.
- `RX_START` goes to `RX_DATA` if the line is still low at mid-start, and back to `RX_IDLE` if it is high.
- `RX_DATA` goes to `RX_ERRWAIT` on a parity error in normal mode, and to `RX_TAIL` otherwise.
- `RX_ERRWAIT` goes to `RX_ERRSIG`.
- `RX_ERRSIG` and `RX_TAIL` go to `RX_IDLE`.

Top module: `sc_xcvr`

## Requirements
- R1: After reset the line is released (`line_oe`=0), `tx_ready`=1, and `rx_valid`, `err_flag` and `retry_fail` are 0.
- R2: A byte accepted with `tx_valid`&`tx_ready` is sent as ten bits of `TPB` ticks each: start (0), data bit 0 to data bit 7, then parity equal to the XOR of the data bits. A 0 is sent with `line_oe`=1 and a 1 with `line_oe`=0. The start bit begins on the clock after acceptance.
- R3: After the parity bit the line stays released for 2·`TPB` ticks. `tx_ready` is low from acceptance until that guard time ends, and `line_oe` is never driven by the transmitter while `tx_ready` is high.
- R4: In normal mode, if the line is low at the tick that ends the first guard bit period (tick `TPB` of the guard), the same byte is sent again right after the guard.
- R5: After `RETRIES` resends the byte is dropped, `retry_fail` pulses for one cycle at the end of that guard, and `tx_ready` returns.
- R6: In block mode the transmitter ignores a low line during the guard and does not resend.
- R7: Reception starts on a tick that sees the line low. The start is confirmed at `TPB`/2 ticks later. Each following bit is sampled `TPB` ticks after the previous one. With good even parity, `rx_data` takes the byte and `rx_valid` pulses for one cycle.
- R8: In normal mode a parity error sets `err_flag`, gives no `rx_valid`, leaves `rx_data` unchanged, and drives `line_oe` high for `ERR_BITS`·`TPB` ticks. The drive starts on tick 1+`TPB`/2+10·`TPB`, counted from the tick that first saw the start bit low.
- R9: In block mode a parity error sets `err_flag` and never drives the line.
- R10: In block mode, while `err_flag` is set at the parity sample, the character is dropped: no `rx_valid`, and `rx_data` is unchanged.
- R11: `err_clr` clears `err_flag`. A parity error in the same cycle wins.
- R12: A low pulse that is high again at the start confirmation is not received and produces no line drive.
- R13: The line is half duplex: `tx_ready` is low while a reception is in progress, and no `rx_valid` comes from the block's own transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing enable, `TPB` pulses per bit period |
| block_mode | input | 1 | 1 = block mode, 0 = normal mode; change only when idle |
| tx_valid | input | 1 | Byte to send is offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| rx_data | output | 8 | Last byte received with good parity |
| err_flag | output | 1 | Parity error seen (sticky) |
| err_clr | input | 1 | Clears `err_flag` |
| retry_fail | output | 1 | One-cycle pulse: byte dropped after the last retry |
| line_in | input | 1 | Level of the shared data line |
| line_oe | output | 1 | 1 = pull the line low, 0 = release |

## Verification
Transmit results are due on clock edges:
- `line_oe` changes on the clock after acceptance and after every `TPB`-th tick.
- `retry_fail` and `tx_ready` change on the clock of the last guard tick.

The bench's tick-indexed model predicts these values and compares them on every falling edge during transmit tests. Receive results are measured in ticks from the first tick that sees the start bit low:
- the parity sample falls on tick 1+`TPB`/2+9·`TPB`;
- `rx_valid` rises one clock after that sample;
- the error drive starts `TPB` ticks later.

The bench samples `line_oe` at the falling edge after each tick and compares the first driven tick and the driven length against these counts.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BITS,
        TX_GUARD
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_TAIL,
        RX_ERRWAIT,
        RX_ERRSIG
    } rx_state_e;

    localparam int FRAME_BITS = 10;
    localparam int DATA_BITS  = 8;

endpackage

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int TPB     = 4,
    parameter int RETRIES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       block_mode,
    input  logic       rx_idle,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       line_in,
    output logic       tx_ready,
    output logic       tx_oe,
    output logic       tx_busy,
    output logic       retry_fail
);
    localparam int CW = $clog2(2 * TPB) + 1;
    localparam int RW = $clog2(RETRIES + 1) + 1;

    tx_state_e        state;
    logic [7:0]       data_q;
    logic [3:0]       bit_idx;
    logic [CW-1:0]    cnt;
    logic [RW-1:0]    tries;
    logic             nak_seen;

    function automatic logic frame_bit(input logic [3:0] idx, input logic [7:0] d);
        if (idx == 4'd0) begin
            return 1'b0;
        end else if (idx == 4'(FRAME_BITS - 1)) begin
            return ^d;
        end else begin
            return d[3'(idx - 4'd1)];
        end
    endfunction

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            data_q     <= '0;
            bit_idx    <= '0;
            cnt        <= '0;
            tries      <= '0;
            nak_seen   <= 1'b0;
            retry_fail <= 1'b0;
        end else begin
            retry_fail <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    tries <= '0;
                    if (tx_valid && rx_idle) begin
                        data_q   <= tx_data;
                        bit_idx  <= '0;
                        cnt      <= '0;
                        nak_seen <= 1'b0;
                        state    <= TX_BITS;
                    end
                end
                TX_BITS: begin
                    if (tick) begin
                        if (cnt == CW'(TPB - 1)) begin
                            cnt <= '0;
                            if (bit_idx == 4'(FRAME_BITS - 1)) begin
                                state <= TX_GUARD;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                TX_GUARD: begin
                    if (tick) begin
                        if (cnt == CW'(TPB - 1) && !line_in) begin
                            nak_seen <= 1'b1;
                        end
                        if (cnt == CW'(2 * TPB - 1)) begin
                            cnt <= '0;
                            if (nak_seen && !block_mode) begin
                                if (tries == RW'(RETRIES)) begin
                                    retry_fail <= 1'b1;
                                    state      <= TX_IDLE;
                                end else begin
                                    tries    <= tries + RW'(1);
                                    bit_idx  <= '0;
                                    nak_seen <= 1'b0;
                                    state    <= TX_BITS;
                                end
                            end else begin
                                state <= TX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_ready = (state == TX_IDLE) && rx_idle;
        tx_busy  = (state != TX_IDLE);
        tx_oe    = (state == TX_BITS) && !frame_bit(bit_idx, data_q);
    end

endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int TPB      = 4,
    parameter int ERR_BITS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       block_mode,
    input  logic       enable,
    input  logic       flag_set,
    input  logic       line_in,
    output logic       rx_oe,
    output logic       rx_idle,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       perr_evt
);
    localparam int HALF  = TPB / 2;
    localparam int ERR_T = ERR_BITS * TPB;
    localparam int MAXC  = (ERR_T > TPB) ? ERR_T : TPB;
    localparam int CW    = $clog2(MAXC) + 1;

    rx_state_e     state;
    logic [7:0]    shreg;
    logic [3:0]    bit_idx;
    logic [CW-1:0] cnt;
    logic          par_bad;

    assign par_bad = ^{line_in, shreg};

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            cnt      <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            perr_evt <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            perr_evt <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (tick && enable && !line_in) begin
                        cnt   <= '0;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            state   <= line_in ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == CW'(TPB - 1)) begin
                            cnt <= '0;
                            if (bit_idx == 4'(DATA_BITS)) begin
                                if (block_mode && flag_set) begin
                                    state <= RX_TAIL;
                                end else if (par_bad) begin
                                    perr_evt <= 1'b1;
                                    state    <= block_mode ? RX_TAIL : RX_ERRWAIT;
                                end else begin
                                    rx_valid <= 1'b1;
                                    rx_data  <= shreg;
                                    state    <= RX_TAIL;
                                end
                            end else begin
                                shreg[bit_idx[2:0]] <= line_in;
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                RX_TAIL, RX_ERRWAIT: begin
                    if (tick) begin
                        if (cnt == CW'(TPB - 1)) begin
                            cnt   <= '0;
                            state <= (state == RX_ERRWAIT) ? RX_ERRSIG : RX_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                RX_ERRSIG: begin
                    if (tick) begin
                        if (cnt == CW'(ERR_T - 1)) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_oe   = (state == RX_ERRSIG);
        rx_idle = (state == RX_IDLE);
    end

endmodule

// File: rtl/sc_errflag.sv
module sc_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr #(
    parameter int TPB      = 4,
    parameter int RETRIES  = 3,
    parameter int ERR_BITS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       block_mode,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       err_flag,
    input  logic       err_clr,
    output logic       retry_fail,
    input  logic       line_in,
    output logic       line_oe
);
    logic tx_oe_w;
    logic tx_busy_w;
    logic rx_oe_w;
    logic rx_idle_w;
    logic perr_w;

    sc_tx #(.TPB(TPB), .RETRIES(RETRIES)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .block_mode (block_mode),
        .rx_idle    (rx_idle_w),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .line_in    (line_in),
        .tx_ready   (tx_ready),
        .tx_oe      (tx_oe_w),
        .tx_busy    (tx_busy_w),
        .retry_fail (retry_fail)
    );

    sc_rx #(.TPB(TPB), .ERR_BITS(ERR_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .block_mode (block_mode),
        .enable     (!tx_busy_w),
        .flag_set   (err_flag),
        .line_in    (line_in),
        .rx_oe      (rx_oe_w),
        .rx_idle    (rx_idle_w),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .perr_evt   (perr_w)
    );

    sc_errflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (perr_w),
        .clr_i  (err_clr),
        .flag_o (err_flag)
    );

    assign line_oe = tx_oe_w | rx_oe_w;

endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_oe,
    input logic rx_oe,
    input logic tx_ready,
    input logic rx_valid,
    input logic retry_fail,
    input logic err_flag,
    input logic err_clr,
    input logic perr_evt,
    input logic block_mode
);
    assert_half_duplex_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_oe && rx_oe));

    assert_busy_rx_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oe |-> !tx_ready);

    assert_ready_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_oe);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_fail_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_fail |=> !retry_fail);

    assert_block_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_mode |-> !$rose(rx_oe));

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && err_clr && !perr_evt) |=> !err_flag);

    assert_flag_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |=> err_flag);
endmodule

bind sc_xcvr sc_xcvr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_oe      (tx_oe_w),
    .rx_oe      (rx_oe_w),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .retry_fail (retry_fail),
    .err_flag   (err_flag),
    .err_clr    (err_clr),
    .perr_evt   (perr_w),
    .block_mode (block_mode)
);

// File: tb/tb_sc_xcvr.sv
module tb_sc_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 4;
    localparam int RETRIES    = 3;
    localparam int ERR_BITS   = 1;
    localparam int DIV        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       block_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       err_clr = 1'b0;
    logic       tx_ready, rx_valid, err_flag, retry_fail, line_oe;
    logic [7:0] rx_data;
    logic       line;
    logic       rx_drive = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // transmit reference model, indexed by ticks since the attempt began
    bit         m_busy = 0;
    int         k = 0;
    bit         m_seen = 0;
    int         m_tries = 0;
    logic [7:0] m_data = '0;
    bit         exp_fail = 0;
    int         nak_left = 0;
    bit         line_n = 1;
    bit         tx_phase = 0;
    string      cur_tag = "R2";

    int vcnt = 0;
    logic [7:0] vdata = '0;
    int fcnt = 0;

    wire remote_nak = m_busy && (nak_left > 0) &&
                      (k >= 10*TPB + TPB/2) && (k < 11*TPB + TPB/2);
    assign line = !(line_oe || rx_drive || remote_nak);

    sc_xcvr #(.TPB(TPB), .RETRIES(RETRIES), .ERR_BITS(ERR_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .block_mode(block_mode),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .err_flag(err_flag),
        .err_clr(err_clr), .retry_fail(retry_fail),
        .line_in(line), .line_oe(line_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            tick = (n % DIV == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit wire_bit(input logic [7:0] d, input int idx);
        logic [9:0] v;
        v = {^d, d, 1'b0};
        return v[idx];
    endfunction

    always @(negedge clk) begin
        line_n <= line;
        if (rx_valid) begin
            vcnt++;
            vdata = rx_data;
        end
        if (retry_fail) fcnt++;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; k = 0; exp_fail = 0;
        end else begin
            exp_fail = 0;
            if (!m_busy) begin
                if (tx_valid) begin
                    m_busy = 1; k = 0; m_seen = 0; m_tries = 0; m_data = tx_data;
                end
            end else if (tick) begin
                if (k == 11*TPB - 1 && !line_n) m_seen = 1;
                if (k == 12*TPB - 1) begin
                    if (nak_left > 0) nak_left--;
                    if (m_seen && !block_mode) begin
                        if (m_tries == RETRIES) begin
                            exp_fail = 1; m_busy = 0;
                        end else begin
                            m_tries++; k = 0; m_seen = 0;
                        end
                    end else begin
                        m_busy = 0;
                    end
                end else begin
                    k++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (tx_phase && rst_n) begin
            bit e_oe;
            e_oe = m_busy && (k < 10*TPB) && !wire_bit(m_data, k / TPB);
            check(line_oe == e_oe, cur_tag, line_oe, e_oe);
            check(tx_ready == !m_busy, "R3", tx_ready, !m_busy);
            check(retry_fail == exp_fail, "R5", retry_fail, exp_fail);
            check(rx_valid == 1'b0, "R13", rx_valid, 0);
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (!tick);
        @(negedge clk);
    endtask

    task automatic send_tx(input logic [7:0] d, input int naks, input string tag);
        nak_left = naks;
        cur_tag = tag;
        tx_phase = 1;
        @(negedge clk);
        tx_data = d;
        tx_valid = 1;
        do @(negedge clk); while (!m_busy);
        tx_valid = 0;
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        tx_phase = 0;
        nak_left = 0;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit bad,
                           output int first, output int cnt, output int rdy10);
        logic [9:0] v;
        v = {(^d) ^ bad, d, 1'b0};
        first = -1; cnt = 0; rdy10 = -1;
        wait_tick();
        rx_drive = !v[0];
        for (int t = 1; t <= 12*TPB; t++) begin
            wait_tick();
            if (line_oe) begin
                if (first < 0) first = t;
                cnt++;
            end
            if (t == 10) rdy10 = tx_ready;
            rx_drive = (t < 10*TPB) ? !v[t / TPB] : 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    localparam int ERR_START = 1 + TPB/2 + 10*TPB;

    initial begin
        int f, c, r, v0, f0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(line_oe == 0, "R1 line", line_oe, 0);
        check(tx_ready == 1, "R1 ready", tx_ready, 1);
        check(rx_valid == 0 && err_flag == 0 && retry_fail == 0, "R1 flags",
              {rx_valid, err_flag, retry_fail}, 0);

        // transmit cases
        f0 = fcnt;
        send_tx(8'hA5, 0, "R2");
        send_tx(8'h17, 1, "R4");
        check(fcnt == f0, "R4 no drop", fcnt - f0, 0);
        send_tx(8'hFF, 99, "R5");
        check(fcnt == f0 + 1, "R5 drop", fcnt - f0, 1);
        block_mode = 1;
        send_tx(8'h00, 1, "R6");
        check(fcnt == f0 + 1, "R6 no resend", fcnt - f0, 1);
        block_mode = 0;
        check(vcnt == 0, "R13 own frames", vcnt, 0);

        // receive cases, normal mode
        send_rx(8'hA5, 0, f, c, r);
        check(vcnt == 1 && vdata == 8'hA5, "R7 byte A5", vdata, 8'hA5);
        check(c == 0, "R7 quiet", c, 0);
        check(r == 0, "R13 ready low", r, 0);
        send_rx(8'h3C, 0, f, c, r);
        check(vcnt == 2 && vdata == 8'h3C, "R7 byte 3C", vdata, 8'h3C);
        v0 = vcnt;
        send_rx(8'h5A, 1, f, c, r);
        check(err_flag == 1, "R8 flag", err_flag, 1);
        check(vcnt == v0 && rx_data == 8'h3C, "R8 no data", rx_data, 8'h3C);
        check(f == ERR_START, "R8 start", f, ERR_START);
        check(c == ERR_BITS*TPB, "R8 length", c, ERR_BITS*TPB);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        check(err_flag == 0, "R11 clear", err_flag, 0);

        // receive cases, block mode
        block_mode = 1;
        send_rx(8'h81, 1, f, c, r);
        check(err_flag == 1, "R9 flag", err_flag, 1);
        check(c == 0, "R9 no drive", c, 0);
        check(vcnt == v0, "R9 no data", vcnt - v0, 0);
        send_rx(8'h42, 0, f, c, r);
        check(vcnt == v0 && rx_data == 8'h3C, "R10 dropped", rx_data, 8'h3C);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        send_rx(8'h42, 0, f, c, r);
        check(vcnt == v0 + 1 && rx_data == 8'h42, "R10 after clear", rx_data, 8'h42);
        check(err_flag == 0, "R11 stays clear", err_flag, 0);
        block_mode = 0;

        // glitch on the line
        v0 = vcnt;
        wait_tick();
        rx_drive = 1;
        wait_tick();
        rx_drive = 0;
        c = 0;
        for (int t = 0; t < 12*TPB; t++) begin
            wait_tick();
            if (line_oe) c++;
        end
        check(vcnt == v0, "R12 no byte", vcnt - v0, 0);
        check(c == 0 && err_flag == 0, "R12 quiet", c, 0);
        check(tx_ready == 1, "R12 idle", tx_ready, 1);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule